// File: doc/BRIEF.md
# Two-Lane ADC Sample Deserializer

This block rebuilds parallel samples from a multi-channel serial ADC link. Each channel delivers one 12-bit two's-complement sample per frame over two serial lanes, one bit per lane per clock, so a sample takes six bit times. A frame marker, sampled alongside the data, is high for the first half of every frame and low for the second half.

The lane split is chosen by a mode input. In interleaved mode one lane carries the even-numbered bits and the other carries the odd-numbered bits. In split mode one lane carries the upper half of the sample and the other carries the lower half. The block does not know where frames begin until it is told to find out. A start pulse runs an alignment search that slips the word boundary one bit time at a time until the six sampled frame-marker bits read three ones followed by three zeros. The block then locks and keeps that boundary. If the link later loses bit sync, the words come out shifted until start is pulsed again. While locked, the block presents all channel samples together with a one-cycle valid strobe at the end of each frame.

Top module: `adc_deser`

## Requirements
- R1: After reset `locked_o` and `valid_o` are 0 and `sample_o` is 0. Without a start pulse, `valid_o` and `locked_o` stay 0 whatever the lanes carry.
- R2: When `mode_i`=0 (interleaved), a sample's bits arrive MSB first over six bit times. At bit time t (0..5), `lane0_i` carries bit 10-2t and `lane1_i` carries bit 11-2t. The rebuilt 12-bit value, two's complement, appears in `sample_o[12c+11:12c]` for channel c.
- R3: When `mode_i`=1 (split), at bit time t `lane0_i` carries bit 11-t and `lane1_i` carries bit 5-t. The value is rebuilt in the same output field.
- R4: A start pulse clears `locked_o` on the next cycle. `locked_o` rises only at a boundary where the six frame bits, oldest first, read 1,1,1,0,0,0. It rises within 13 cycles of the start pulse.
- R5: `valid_o` is high only while `locked_o` is high. While locked it is high for exactly one cycle in every six.
- R6: `valid_o` and the new samples appear in the cycle after the clock edge that captures bit time 5 of a frame. `sample_o` holds its value between strobes.
- R7: Once locked, the boundary is kept without rechecking. A lost or gained bit time on the link leaves `locked_o` high and yields shifted words.
- R8: A new start pulse after a loss of sync restores correctly aligned samples.
- R9: The mode is applied per word at the frame's final bit. Switching the mode between frames changes the decoding from the next word on, with no new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one lane bit per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse to run the alignment search |
| mode_i | input | 1 | Lane split: 0 interleaved, 1 split |
| frame_i | input | 1 | Sampled frame marker |
| lane0_i | input | 4 | First serial lane of each channel |
| lane1_i | input | 4 | Second serial lane of each channel |
| sample_o | output | 48 | Rebuilt samples, channel c at bits 12c+11..12c |
| valid_o | output | 1 | One-cycle strobe for a new sample set |
| locked_o | output | 1 | Word alignment established |

## Verification
A sample set is due one cycle after the edge that takes in the sixth bit time of its frame. The bench drives bit time 5 on a falling edge and expects the strobe and the matching values at the next falling edge. It expects no strobe at every other falling edge while locked. `locked_o` must be low one cycle after a start pulse and must rise within 13 cycles. The bench counts cycles from the pulse and begins strict per-cycle checking only after it sees the lock. After an injected four-bit gap, the bench checks the lock flag and the shifted words on the strobes that follow, then pulses start again and resumes exact checks.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  typedef enum logic [1:0] {
    ALN_IDLE   = 2'd0,
    ALN_SEARCH = 2'd1,
    ALN_LOCK   = 2'd2
  } align_state_e;

  typedef enum logic {
    SPLIT_INTERLEAVE = 1'b0,
    SPLIT_HALVES     = 1'b1
  } split_mode_e;
endpackage

// File: rtl/shift_tap.sv
module shift_tap #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d,
  output logic [W-1:0] win
);
  logic [W-1:0] sh;

  // win includes the bit arriving at this edge; win[W-1] is the oldest bit
  assign win = {sh[W-2:0], d};

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= win;
  end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import adc_deser_pkg::*;
#(
  parameter int LANE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LANE_BITS-1:0] fwin,
  output logic                 word_end,
  output logic                 frame_match,
  output logic                 capture_fire,
  output logic                 locked
);
  localparam int CW   = (LANE_BITS > 1) ? $clog2(LANE_BITS) : 1;
  localparam int HALF = LANE_BITS / 2;

  function automatic logic [LANE_BITS-1:0] marker_pattern();
    logic [LANE_BITS-1:0] p;
    for (int i = 0; i < LANE_BITS; i++) p[i] = (i >= LANE_BITS - HALF);
    return p;
  endfunction

  localparam logic [LANE_BITS-1:0] PAT = marker_pattern();
  localparam logic [CW-1:0] LAST = CW'(LANE_BITS - 1);

  align_state_e state;
  logic [CW-1:0] cnt;

  assign word_end     = (state != ALN_IDLE) && (cnt == LAST);
  assign frame_match  = word_end && (fwin == PAT);
  assign capture_fire = !start && word_end &&
                        ((state == ALN_LOCK) || frame_match);
  assign locked       = (state == ALN_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ALN_IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= ALN_SEARCH;
      cnt   <= '0;
    end else begin
      unique case (state)
        ALN_SEARCH: begin
          if (frame_match) begin
            state <= ALN_LOCK;
            cnt   <= '0;
          end else if (!word_end) begin
            cnt <= cnt + 1'b1;
          end
          // mismatch at boundary: hold cnt, slipping the boundary one bit
        end
        ALN_LOCK: cnt <= word_end ? '0 : cnt + 1'b1;
        default:  cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/word_pack.sv
module word_pack
  import adc_deser_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                  mode,
  input  logic [SAMPLE_W/2-1:0] w0,
  input  logic [SAMPLE_W/2-1:0] w1,
  output logic [SAMPLE_W-1:0]   word
);
  localparam int LB = SAMPLE_W / 2;

  function automatic logic [SAMPLE_W-1:0] merge_interleaved(
    input logic [LB-1:0] ev, input logic [LB-1:0] od);
    logic [SAMPLE_W-1:0] r;
    for (int k = 0; k < LB; k++) begin
      r[2*k]   = ev[k];
      r[2*k+1] = od[k];
    end
    return r;
  endfunction

  function automatic logic [SAMPLE_W-1:0] merge_halves(
    input logic [LB-1:0] hi, input logic [LB-1:0] lo);
    return {hi, lo};
  endfunction

  always_comb begin
    if (split_mode_e'(mode) == SPLIT_HALVES) word = merge_halves(w0, w1);
    else                                     word = merge_interleaved(w0, w1);
  end
endmodule

// File: rtl/adc_deser.sv
module adc_deser
  import adc_deser_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         mode_i,
  input  logic                         frame_i,
  input  logic [CHANNELS-1:0]          lane0_i,
  input  logic [CHANNELS-1:0]          lane1_i,
  output logic [CHANNELS*SAMPLE_W-1:0] sample_o,
  output logic                         valid_o,
  output logic                         locked_o
);
  localparam int LB = SAMPLE_W / 2;

  logic [LB-1:0] fwin;
  logic          word_end;
  logic          frame_match;
  logic          capture_fire;
  logic [CHANNELS*SAMPLE_W-1:0] packed_words;

  shift_tap #(.W(LB)) u_frame_tap (
    .clk(clk), .rst_n(rst_n), .d(frame_i), .win(fwin)
  );

  frame_aligner #(.LANE_BITS(LB)) u_align (
    .clk(clk), .rst_n(rst_n), .start(start_i), .fwin(fwin),
    .word_end(word_end), .frame_match(frame_match),
    .capture_fire(capture_fire), .locked(locked_o)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [LB-1:0] w0;
    logic [LB-1:0] w1;

    shift_tap #(.W(LB)) u_tap0 (
      .clk(clk), .rst_n(rst_n), .d(lane0_i[c]), .win(w0)
    );
    shift_tap #(.W(LB)) u_tap1 (
      .clk(clk), .rst_n(rst_n), .d(lane1_i[c]), .win(w1)
    );
    word_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
      .mode(mode_i), .w0(w0), .w1(w1),
      .word(packed_words[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= capture_fire;
      if (capture_fire) sample_o <= packed_words;
    end
  end
endmodule

// File: rtl/adc_deser_chk.sv
module adc_deser_chk #(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic                         valid_o,
  input logic                         locked_o,
  input logic [CHANNELS*SAMPLE_W-1:0] sample_o,
  input logic                         capture_fire,
  input logic                         frame_match
);
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> locked_o); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R5
  AST_START_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !locked_o); // R4
  AST_LOCK_FROM_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(frame_match)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !start_i) |=> locked_o); // R7
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_fire |=> $stable(sample_o)); // R6
endmodule

bind adc_deser adc_deser_chk #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_o(valid_o),
  .locked_o(locked_o), .sample_o(sample_o),
  .capture_fire(capture_fire), .frame_match(frame_match)
);

// File: tb/tb_adc_deser.sv
module tb_adc_deser;
  localparam int CH = 4;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic frame_i = 1'b0;
  logic [CH-1:0] lane0_i = '0;
  logic [CH-1:0] lane1_i = '0;
  logic [CH*SW-1:0] sample_o;
  logic valid_o;
  logic locked_o;

  adc_deser #(.CHANNELS(CH), .SAMPLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .frame_i(frame_i), .lane0_i(lane0_i), .lane1_i(lane1_i),
    .sample_o(sample_o), .valid_o(valid_o), .locked_o(locked_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int total = 0;
  int bad = 0;
  bit done = 0;

  int bi = 0, fno = 0, gap = 0;
  bit strict = 0, end_prev = 0, start_req = 0, next_mode = 0, frm_mode = 0;
  bit exp_mode = 0;
  logic [SW-1:0] cur [CH];
  logic [SW-1:0] exp_s [CH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] gen(input int f, input int c);
    if (f % 16 == 0) begin
      case (c)
        0: return 12'h800;
        1: return 12'h7FF;
        2: return 12'hFFF;
        default: return 12'h000;
      endcase
    end
    if (f % 16 == 1) return 12'(1 << ((f / 16 + c) % SW));
    return 12'((f * 97 + c * 1373 + (f >> 3) * 5) & 12'hFFF);
  endfunction

  task automatic step();
    @(negedge clk);
    if (strict) begin
      if (end_prev) begin
        chk(valid_o === 1'b1, "R6 valid after last bit", valid_o, 1);
        for (int c = 0; c < CH; c++)
          chk(sample_o[c*SW +: SW] === exp_s[c], exp_mode ? "R3 split decode" : "R2 interleaved decode",
              sample_o[c*SW +: SW], exp_s[c]);
      end else begin
        chk(valid_o === 1'b0, "R5 one strobe per frame", valid_o, 0);
      end
    end
    start_i = start_req;
    start_req = 0;
    if (gap > 0) begin
      gap--;
      lane0_i = '0; lane1_i = '0; frame_i = 1'b0;
      end_prev = 0;
    end else begin
      if (bi == 0) begin
        frm_mode = next_mode;
        mode_i = next_mode;
        for (int c = 0; c < CH; c++) cur[c] = gen(fno, c);
      end
      for (int c = 0; c < CH; c++) begin
        if (!frm_mode) begin
          lane0_i[c] = cur[c][10 - 2*bi];
          lane1_i[c] = cur[c][11 - 2*bi];
        end else begin
          lane0_i[c] = cur[c][11 - bi];
          lane1_i[c] = cur[c][5 - bi];
        end
      end
      frame_i = (bi < 3);
      end_prev = (bi == 5);
      if (end_prev) begin
        for (int c = 0; c < CH; c++) exp_s[c] = cur[c];
        exp_mode = frm_mode;
        fno++;
      end
      bi = (bi + 1) % 6;
    end
  endtask

  task automatic do_lock(input string req);
    int n;
    start_req = 1;
    strict = 0;
    step();
    step();
    chk(locked_o === 1'b0, "R4 start clears lock", locked_o, 0);
    n = 1;
    while (locked_o !== 1'b1 && n < 20) begin
      step();
      n++;
    end
    chk(n <= 13, req, n, 13);
    strict = 1;
  endtask

  initial begin
    int mis;
    repeat (3) @(negedge clk);
    chk(locked_o === 1'b0 && valid_o === 1'b0, "R1 reset flags", {locked_o, valid_o}, 0);
    chk(sample_o === '0, "R1 reset samples", sample_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      step();
      chk(valid_o === 1'b0 && locked_o === 1'b0, "R1 idle without start", {locked_o, valid_o}, 0);
    end

    do_lock("R4 lock within bound");
    repeat (150 * 6) step();

    next_mode = 1;
    while (bi != 0) step();
    repeat (150 * 6) step();
    chk(locked_o === 1'b1, "R9 mode switch keeps lock", locked_o, 1);

    next_mode = 0;
    repeat (20 * 6) step();

    strict = 0;
    while (bi != 2) step();
    gap = 4;
    mis = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      chk(locked_o === 1'b1, "R7 lock holds after slip", locked_o, 1);
      if (valid_o === 1'b1 && sample_o[SW-1:0] !== exp_s[0]) mis++;
    end
    chk(mis >= 1, "R7 words shifted after slip", mis, 1);

    next_mode = 1;
    do_lock("R8 relock after slip");
    repeat (60 * 6) step();
    chk(locked_o === 1'b1, "R8 aligned after relock", locked_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule